// File: doc/BRIEF.md
# SPI Transmit Queue with Status Flags

This block buffers outgoing SPI frames between a push-write port (driven by software or by a DMA engine) and the shift engine of an SPI port. Each 32-bit entry carries a command half in bits 31:16 and a data half in bits 15:0. The shift engine sees the oldest entry on `head_word` whenever `head_valid` is high. It takes that entry with a one-cycle `load_strobe`. It reports the end of each frame with `eot_strobe`.

Alongside the queue the block keeps status for the register file. It holds the entry count and the index of the slot that goes out next. It keeps a fill flag that requests more data through either a DMA request or an interrupt line. It keeps a sticky transfer-complete flag and a sticky underflow flag. The underflow flag catches an external master that starts a frame while the queue is empty in slave mode. A flush command empties the queue in one cycle.

Top module: `spi_txq`

## Requirements
- R1: A `push_valid` cycle while `level` is below DEPTH (4) writes `push_word` at the tail and raises `level` by one on the next edge.
- R2: A `push_valid` cycle while `level` equals DEPTH is dropped: `level`, `next_ptr` and the stored entries stay unchanged, and no flag reports it.
- R3: A `load_strobe` cycle with `level` above 0 removes the head entry and lowers `level` by exactly one. A push and a load in the same cycle leave `level` unchanged. A load on an empty queue has no effect.
- R4: `next_ptr` gives the slot index of the head entry, counted in 32-bit words. It advances by one per accepted load and wraps from DEPTH-1 to 0.
- R5: `head_word` shows the oldest stored entry, so words leave in push order. `head_valid` is high exactly when `level` is non-zero.
- R6: A `flush` cycle sets `level` and `next_ptr` to 0 on the next edge. It wins over a push or load in the same cycle.
- R7: `fill_flag` is set on the edge after any cycle in which the queue is not full and `fill_w1c` is low.
- R8: `fill_flag` clears on the edge after a cycle with `fill_w1c` high, or with the queue full and `dma_push_done` high. While the queue stays full, it stays clear.
- R9: With `req_to_dma` high, `fill_dma_req` follows `fill_flag` and `fill_irq` is 0. With `req_to_dma` low, the two swap roles.
- R10: `tcf_flag` is set on the edge after an `eot_strobe` cycle. It is cleared by `tcf_w1c`, and a set in the same cycle wins.
- R11: `uf_flag` is set on the edge after a cycle with `slave_mode`, `ext_start` and an empty queue all true. It is not set in master mode or when the queue holds data. It is cleared by `uf_w1c`, and a set in the same cycle wins.
- R12: After reset, `level`, `next_ptr`, `tcf_flag`, `uf_flag` and `head_valid` are 0 and `fill_flag` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Write to the push register this cycle |
| push_word | input | 32 | Entry to push: command 31:16, data 15:0 |
| dma_push_done | input | 1 | DMA signals completion of a push write |
| fill_w1c | input | 1 | Software write of 1 to the fill flag |
| flush | input | 1 | Clear-transmit control write |
| load_strobe | input | 1 | Shift engine takes the head entry |
| eot_strobe | input | 1 | End of an SPI transfer |
| ext_start | input | 1 | External master begins a transfer |
| slave_mode | input | 1 | Port operates as slave |
| req_to_dma | input | 1 | Route fill request to DMA (1) or interrupt (0) |
| tcf_w1c | input | 1 | Software write of 1 to transfer-complete flag |
| uf_w1c | input | 1 | Software write of 1 to underflow flag |
| head_word | output | 32 | Oldest entry |
| head_valid | output | 1 | Queue holds at least one entry |
| level | output | 3 | Number of valid entries |
| next_ptr | output | 2 | Slot index of the next entry to send |
| fill_flag | output | 1 | Queue can take data |
| fill_dma_req | output | 1 | Fill request toward DMA |
| fill_irq | output | 1 | Fill request toward interrupt controller |
| tcf_flag | output | 1 | Transfer-complete flag |
| uf_flag | output | 1 | Underflow flag |

## Verification
Every registered result, including `level`, `next_ptr` and the three flags, appears on the first rising edge after the cycle whose inputs caused it. `head_word`, `head_valid` and the two request outputs follow that state with no further delay. The bench changes inputs just after a rising edge and compares all outputs at the falling edge in between. At that point the reference model holds the state from the previous edge. The model then steps once using the inputs seen at that same falling edge, so each compare lines up with exactly one edge of latency.

// File: rtl/spi_txq_pkg.sv
package spi_txq_pkg;

  // Modulo increment of a slot index.
  function automatic int unsigned wrap_inc(input int unsigned idx, input int unsigned depth);
    return (idx + 1) % depth;
  endfunction

  // Entry count after an optional add and an optional remove.
  function automatic int unsigned level_step(input int unsigned lvl, input logic add, input logic sub);
    return lvl + (add ? 1 : 0) - (sub ? 1 : 0);
  endfunction

  typedef struct packed {
    logic set;
    logic clr;
  } flag_evt_t;

endpackage

// File: rtl/spi_txq_store.sv
module spi_txq_store
  import spi_txq_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_ok,
  input  logic             pop_ok,
  input  logic             flush,
  input  logic [WIDTH-1:0] push_word,
  output logic [WIDTH-1:0] head_word,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] count
);

  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic [WIDTH-1:0] slot [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= PTR_W'(wrap_inc(32'(wr_q), DEPTH));
      if (pop_ok)  rd_q <= PTR_W'(wrap_inc(32'(rd_q), DEPTH));
      cnt_q <= CNT_W'(level_step(32'(cnt_q), push_ok, pop_ok));
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot[i] <= '0;
      else if (push_ok && !flush && wr_q == PTR_W'(i))
        slot[i] <= push_word;
    end
  end

  assign head_word = slot[rd_q];
  assign rd_ptr    = rd_q;
  assign count     = cnt_q;

endmodule

// File: rtl/spi_txq_sticky.sv
module spi_txq_sticky
  import spi_txq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_evt_t evt,
  output logic      flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (evt.set) flag <= 1'b1;
    else if (evt.clr) flag <= 1'b0;
  end

endmodule

// File: rtl/spi_txq_fill.sv
module spi_txq_fill (
  input  logic clk,
  input  logic rst_n,
  input  logic full,
  input  logic dma_push_done,
  input  logic sw_clear,
  input  logic req_to_dma,
  output logic flag,
  output logic dma_req,
  output logic irq_req
);

  logic clear_evt;
  assign clear_evt = sw_clear || (full && dma_push_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag <= 1'b1;
    else if (clear_evt) flag <= 1'b0;
    else if (!full)     flag <= 1'b1;
  end

  assign dma_req = flag && req_to_dma;
  assign irq_req = flag && !req_to_dma;

endmodule

// File: rtl/spi_txq.sv
module spi_txq
  import spi_txq_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned WIDTH = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_valid,
  input  logic [WIDTH-1:0]             push_word,
  input  logic                         dma_push_done,
  input  logic                         fill_w1c,
  input  logic                         flush,
  input  logic                         load_strobe,
  input  logic                         eot_strobe,
  input  logic                         ext_start,
  input  logic                         slave_mode,
  input  logic                         req_to_dma,
  input  logic                         tcf_w1c,
  input  logic                         uf_w1c,
  output logic [WIDTH-1:0]             head_word,
  output logic                         head_valid,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic [$clog2(DEPTH)-1:0]     next_ptr,
  output logic                         fill_flag,
  output logic                         fill_dma_req,
  output logic                         fill_irq,
  output logic                         tcf_flag,
  output logic                         uf_flag
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  // Named internal events, visible to the bound checker.
  logic      full, empty, push_ok, pop_ok, uf_hit;
  flag_evt_t tcf_evt, uf_evt;

  assign full    = (level == CNT_W'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push_valid && !full;
  assign pop_ok  = load_strobe && !empty;
  assign uf_hit  = slave_mode && ext_start && empty;

  assign tcf_evt = '{set: eot_strobe, clr: tcf_w1c};
  assign uf_evt  = '{set: uf_hit,     clr: uf_w1c};

  spi_txq_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_ok   (push_ok),
    .pop_ok    (pop_ok),
    .flush     (flush),
    .push_word (push_word),
    .head_word (head_word),
    .rd_ptr    (next_ptr),
    .count     (level)
  );

  spi_txq_fill u_fill (
    .clk           (clk),
    .rst_n         (rst_n),
    .full          (full),
    .dma_push_done (dma_push_done),
    .sw_clear      (fill_w1c),
    .req_to_dma    (req_to_dma),
    .flag          (fill_flag),
    .dma_req       (fill_dma_req),
    .irq_req       (fill_irq)
  );

  spi_txq_sticky u_tcf (.clk(clk), .rst_n(rst_n), .evt(tcf_evt), .flag(tcf_flag));
  spi_txq_sticky u_uf  (.clk(clk), .rst_n(rst_n), .evt(uf_evt),  .flag(uf_flag));

  assign head_valid = !empty;

endmodule

// File: rtl/spi_txq_checker.sv
module spi_txq_checker
  import spi_txq_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_valid,
  input logic             load_strobe,
  input logic             flush,
  input logic             dma_push_done,
  input logic             fill_w1c,
  input logic             eot_strobe,
  input logic             ext_start,
  input logic             slave_mode,
  input logic [CNT_W-1:0] level,
  input logic [PTR_W-1:0] next_ptr,
  input logic [WIDTH-1:0] head_word,
  input logic             fill_flag,
  input logic             tcf_flag,
  input logic             uf_flag,
  input logic             push_ok,
  input logic             pop_ok
);

  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok && !pop_ok && !flush |=> level == $past(level) + CNT_W'(1)); // R1

  AST_FULL_PUSH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    level == CNT_W'(DEPTH) && push_valid && !load_strobe && !flush
    |=> level == CNT_W'(DEPTH) && $stable(next_ptr) && $stable(head_word)); // R2

  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    level != '0 && load_strobe && !push_valid && !flush |=> level == $past(level) - CNT_W'(1)); // R3

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CNT_W'(DEPTH)); // R3

  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok && !flush |=> next_ptr == PTR_W'(wrap_inc(32'($past(next_ptr)), DEPTH))); // R4

  AST_FLUSH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> level == '0 && next_ptr == '0); // R6

  AST_FILL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    level != CNT_W'(DEPTH) && !fill_w1c |=> fill_flag); // R7

  AST_FILL_DMA_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    level == CNT_W'(DEPTH) && dma_push_done |=> !fill_flag); // R8

  AST_TCF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    eot_strobe |=> tcf_flag); // R10

  AST_UF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode && ext_start && level == '0 |=> uf_flag); // R11

endmodule

bind spi_txq spi_txq_checker #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .push_valid    (push_valid),
  .load_strobe   (load_strobe),
  .flush         (flush),
  .dma_push_done (dma_push_done),
  .fill_w1c      (fill_w1c),
  .eot_strobe    (eot_strobe),
  .ext_start     (ext_start),
  .slave_mode    (slave_mode),
  .level         (level),
  .next_ptr      (next_ptr),
  .head_word     (head_word),
  .fill_flag     (fill_flag),
  .tcf_flag      (tcf_flag),
  .uf_flag       (uf_flag),
  .push_ok       (push_ok),
  .pop_ok        (pop_ok)
);

// File: tb/spi_txq_bench.sv
module spi_txq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_valid = 0, dma_push_done = 0, fill_w1c = 0, flush = 0;
  logic        load_strobe = 0, eot_strobe = 0, ext_start = 0, slave_mode = 0;
  logic        req_to_dma = 0, tcf_w1c = 0, uf_w1c = 0;
  logic [31:0] push_word = '0;
  logic [31:0] head_word;
  logic        head_valid, fill_flag, fill_dma_req, fill_irq, tcf_flag, uf_flag;
  logic [2:0]  level;
  logic [1:0]  next_ptr;

  int n_run = 0;
  int n_fail = 0;
  bit mon_en = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_txq u_spi_txq (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_word(push_word),
    .dma_push_done(dma_push_done), .fill_w1c(fill_w1c), .flush(flush),
    .load_strobe(load_strobe), .eot_strobe(eot_strobe), .ext_start(ext_start),
    .slave_mode(slave_mode), .req_to_dma(req_to_dma), .tcf_w1c(tcf_w1c),
    .uf_w1c(uf_w1c), .head_word(head_word), .head_valid(head_valid),
    .level(level), .next_ptr(next_ptr), .fill_flag(fill_flag),
    .fill_dma_req(fill_dma_req), .fill_irq(fill_irq), .tcf_flag(tcf_flag),
    .uf_flag(uf_flag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Scoreboard: expected entries, in push order, and the model's status.
  logic [31:0] exp_q[$];
  int    m_ptr = 0;
  bit    m_fill = 1, m_tcf = 0, m_uf = 0;
  string lvl_tag = "R3", ptr_tag = "R4", fill_tag = "R7";

  always @(negedge clk) begin
    if (mon_en) begin
      bit full_now, empty_now;
      chk(lvl_tag, 32'(level), exp_q.size());
      chk(ptr_tag, 32'(next_ptr), m_ptr);
      chk("R5", 32'(head_valid), 32'(exp_q.size() > 0));
      if (exp_q.size() > 0) chk("R5", head_word, exp_q[0]);
      chk(fill_tag, 32'(fill_flag), 32'(m_fill));
      chk("R9", 32'(fill_dma_req), 32'(m_fill && req_to_dma));
      chk("R9", 32'(fill_irq), 32'(m_fill && !req_to_dma));
      chk("R10", 32'(tcf_flag), 32'(m_tcf));
      chk("R11", 32'(uf_flag), 32'(m_uf));

      // Step the model with the inputs applied at the coming edge.
      full_now  = (exp_q.size() == DEPTH);
      empty_now = (exp_q.size() == 0);
      if (fill_w1c || (full_now && dma_push_done)) begin m_fill = 0; fill_tag = "R8"; end
      else begin if (!full_now) m_fill = 1; fill_tag = "R7"; end
      if (eot_strobe) m_tcf = 1; else if (tcf_w1c) m_tcf = 0;
      if (slave_mode && ext_start && empty_now) m_uf = 1; else if (uf_w1c) m_uf = 0;
      if (flush) begin
        exp_q.delete(); m_ptr = 0; lvl_tag = "R6"; ptr_tag = "R6";
      end else begin
        lvl_tag = (push_valid && full_now) ? "R2" : (push_valid ? "R1" : "R3");
        ptr_tag = "R4";
        if (load_strobe && !empty_now) begin
          void'(exp_q.pop_front());
          m_ptr = (m_ptr + 1) % DEPTH;
        end
        if (push_valid && !full_now) exp_q.push_back(push_word);
      end
    end
  end

  task automatic drive(input bit pv, input logic [31:0] w, input bit ld, input bit fl,
                       input bit dd, input bit fw, input bit eot, input bit ext,
                       input bit tw, input bit uw);
    push_valid = pv; push_word = w; load_strobe = ld; flush = fl;
    dma_push_done = dd; fill_w1c = fw; eot_strobe = eot; ext_start = ext;
    tcf_w1c = tw; uf_w1c = uw;
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, '0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic push(input logic [31:0] w);
    drive(1, w, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic load();
    drive(0, '0, 1, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: reset state
    chk("R12", 32'(level), 0);
    chk("R12", 32'(next_ptr), 0);
    chk("R12", 32'(head_valid), 0);
    chk("R12", 32'(fill_flag), 1);
    chk("R12", 32'(tcf_flag), 0);
    chk("R12", 32'(uf_flag), 0);
    @(posedge clk); #1;
    rst_n = 1; mon_en = 1;
    idle(1);

    // R1 fill to full, R2 drop while full
    push(32'hA001_0011); push(32'hA002_0022); push(32'hA003_0033); push(32'hA004_0044);
    push(32'hDEAD_BEEF); push(32'hDEAD_BEE0);
    // R8: DMA completion while full clears fill flag; stays clear
    drive(0, '0, 0, 0, 1, 0, 0, 0, 0, 0);
    idle(2);
    // R3/R4/R5: one load, fill rises again (R7)
    load(); idle(1);
    // R8: software clear while not full
    drive(0, '0, 0, 0, 0, 1, 0, 0, 0, 0);
    idle(2);
    // R3: push and load together
    drive(1, 32'hB005_0055, 1, 0, 0, 0, 0, 0, 0, 0);
    // drain past empty, pointer wraps
    for (int i = 0; i < 6; i++) load();
    for (int i = 0; i < 5; i++) push(32'hC000_0000 + i);
    for (int i = 0; i < 3; i++) load();
    // R6: flush beats push and load
    drive(1, 32'hEEEE_0001, 1, 1, 0, 0, 0, 0, 0, 0);
    idle(1);
    push(32'hF000_0001); push(32'hF000_0002); load();
    // R10: set, set+clear together, clear
    drive(0, '0, 0, 0, 0, 0, 1, 0, 0, 0);
    drive(0, '0, 0, 0, 0, 0, 1, 0, 1, 0);
    drive(0, '0, 0, 0, 0, 0, 0, 0, 1, 0);
    idle(1);
    // R11: slave with data -> no flag; master empty -> no flag; slave empty -> flag
    slave_mode = 1;
    drive(0, '0, 0, 0, 0, 0, 0, 1, 0, 0);
    load(); idle(1);
    slave_mode = 0;
    drive(0, '0, 0, 0, 0, 0, 0, 1, 0, 0);
    slave_mode = 1;
    drive(0, '0, 0, 0, 0, 0, 0, 1, 0, 0);
    drive(0, '0, 0, 0, 0, 0, 0, 1, 0, 1);
    drive(0, '0, 0, 0, 0, 0, 0, 0, 0, 1);
    idle(1);
    // R9: route to DMA
    req_to_dma = 1; idle(2);
    push(32'h1234_5678); push(32'h1234_5679); push(32'h1234_567A); push(32'h1234_567B);
    idle(1); load(); idle(1);

    // Mixed traffic
    for (int i = 0; i < 3000; i++) begin
      slave_mode = $urandom_range(1, 0);
      if ($urandom_range(50, 0) == 0) req_to_dma = ~req_to_dma;
      drive($urandom_range(1, 0), $urandom, $urandom_range(2, 0) == 0,
            $urandom_range(60, 0) == 0, $urandom_range(4, 0) == 0,
            $urandom_range(10, 0) == 0, $urandom_range(6, 0) == 0,
            $urandom_range(8, 0) == 0, $urandom_range(5, 0) == 0,
            $urandom_range(5, 0) == 0);
    end
    idle(2);
    finish_run();
  end

endmodule